// File: doc/BRIEF.md
# Dual-Retire In-Order Completion Queue

This block follows instructions from dispatch to retirement. Dispatch hands it up to two instructions per cycle, each naming an architectural destination register. The block gives each instruction a queue slot, and that slot's index doubles as the tag of its private rename register. Execution units may finish work in any order. Each one reports a tag, a result value and an exception flag; the value lands in the rename register, never directly in the architectural file.

Retirement runs strictly in program order from the head of the queue, at most two instructions per cycle. A retiring instruction's rename value is copied into its architectural register. An exception is acted on only when the faulting instruction is the oldest one in flight. At that point the block raises an interrupt request naming the faulting tag, commits nothing from it, and discards every entry in the queue in the same cycle. The architectural file is therefore exact at the faulting instruction. A read port lets the surrounding logic observe the architectural file.

Top module: `dualRetireQueue`

## Requirements
- R1: After reset `dispReady` is 1, `retireValid` is 0, `excReq` is 0, `dispTag0`/`dispTag1` are 0/1 and every architectural register reads 0.
- R2: When `dispReady` is 1, `dispValid[0]` takes one entry at slot `dispTag0`, and `dispValid[1]` together with it takes a second, younger entry at `dispTag1`. The slot following slot DEPTH-1 is slot 0, so the tag pair advances by the number taken, modulo DEPTH.
- R3: `dispReady` is 0 while fewer than two slots are free, and in any cycle where `excReq` is 1. Dispatch offered while it is 0 is ignored and the tags do not move.
- R4: A finish report writes the rename register of its tag only. The architectural file is unchanged until that entry retires.
- R5: A finished entry does not retire while any older entry is still unfinished.
- R6: `retireValid[0]` marks the oldest entry retiring this cycle and `retireValid[1]` the next one. The second retires only if the first also retires and the second is finished without an exception.
- R7: On the clock edge of retirement, the entry's rename value is written to its architectural destination. If two entries retiring in the same cycle share a destination, the younger value remains.
- R8: When the oldest entry is finished with its exception flag set, `excReq` is 1 and `excTag` is its slot, and nothing retires. At that edge every entry is discarded, so the queue is empty in the next cycle and the architectural file keeps its old contents.
- R9: If the second-oldest entry has an exception, the oldest still retires alone, and `excReq` is raised in the following cycle.
- R10: A finish report for a tag that is not in flight, or that has already finished, is ignored.
- R11: `dispValid[1]` without `dispValid[0]` dispatches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 2 | Dispatch lanes; bit 0 is the older instruction |
| dispDest0 | input | ARCH_W | Architectural destination, lane 0 |
| dispDest1 | input | ARCH_W | Architectural destination, lane 1 |
| dispReady | output | 1 | Two dispatch entries can be taken this cycle |
| dispTag0 | output | TAG_W | Slot/rename tag given to lane 0 |
| dispTag1 | output | TAG_W | Slot/rename tag given to lane 1 |
| finValid | input | 2 | Finish report valid, one bit per report port |
| finTag0 | input | TAG_W | Tag of report port 0 |
| finTag1 | input | TAG_W | Tag of report port 1 |
| finData0 | input | DATA_W | Result value, port 0 |
| finData1 | input | DATA_W | Result value, port 1 |
| finExc | input | 2 | Exception flag per report port |
| retireValid | output | 2 | Entries retiring this cycle (bit 0 oldest) |
| excReq | output | 1 | Precise interrupt request; queue flushed at this edge |
| excTag | output | TAG_W | Tag of the faulting entry |
| archRdAddr | input | ARCH_W | Architectural file read address |
| archRdData | output | DATA_W | Architectural file read data |

## Verification
On every cycle, assertions check the queue's structural consistency: the occupancy bound, that a finished mark only exists on an in-flight slot, that dispatch targets a free slot, that retirement starts from an in-flight head, that an exception leaves an empty queue, and that finish writes never collide with a retiring slot. The bench's directed scenarios are needed to show the ordering and data behaviours: out-of-order finish held back until the head is done, paired retirement, younger-wins on a shared destination, refusal of dispatch when full, ignored finish reports, and the exact architectural contents around an exception at the first or second position.

// File: rtl/drqPkg.sv
package drqPkg;
  typedef struct packed {
    logic [1:0] dispWe;
    logic [1:0] finWe;
    logic [1:0] retWe;
  } drqStrobes_t;
endpackage

// File: rtl/drqCtrl.sv
module drqCtrl
  import drqPkg::*;
#(
  parameter int DEPTH = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       dispValid,
  output logic             dispReady,
  output logic [TAG_W-1:0] dispTag0,
  output logic [TAG_W-1:0] dispTag1,
  input  logic [1:0]       finValid,
  input  logic [TAG_W-1:0] finTag0,
  input  logic [TAG_W-1:0] finTag1,
  input  logic [1:0]       finExc,
  output logic [1:0]       retireValid,
  output logic             excReq,
  output logic [TAG_W-1:0] excTag,
  output logic [TAG_W-1:0] headSlot,
  output logic [TAG_W-1:0] nextSlot,
  output drqStrobes_t      strobes
);
  logic [TAG_W-1:0] head, tail, tailNext;
  logic [CNT_W-1:0] count, freeSlots;
  logic [DEPTH-1:0] busy, done, excF;
  logic             headDone, takeExc, ret0, ret1;

  function automatic logic [TAG_W-1:0] wrapInc(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic tagInRange(input logic [TAG_W-1:0] t);
    return {1'b0, t} < (TAG_W + 1)'(DEPTH);
  endfunction

  always_comb begin
    headSlot  = head;
    nextSlot  = wrapInc(head);
    tailNext  = wrapInc(tail);
    freeSlots = CNT_W'(DEPTH) - count;
    headDone  = (count != '0) && done[head];
    takeExc   = headDone && excF[head];
    ret0      = headDone && !excF[head];
    ret1      = ret0 && (count >= CNT_W'(2)) && done[nextSlot] && !excF[nextSlot];
    dispReady = (freeSlots >= CNT_W'(2)) && !takeExc;
    strobes.dispWe[0] = dispReady && dispValid[0];
    strobes.dispWe[1] = dispReady && dispValid[0] && dispValid[1];
    strobes.finWe[0]  = finValid[0] && tagInRange(finTag0) && busy[finTag0] && !done[finTag0];
    strobes.finWe[1]  = finValid[1] && tagInRange(finTag1) && busy[finTag1] && !done[finTag1];
    strobes.retWe     = {ret1, ret0};
    retireValid = {ret1, ret0};
    excReq      = takeExc;
    excTag      = head;
    dispTag0    = tail;
    dispTag1    = tailNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      busy  <= '0;
      done  <= '0;
      excF  <= '0;
    end else if (takeExc) begin
      busy  <= '0;
      done  <= '0;
      excF  <= '0;
      count <= '0;
      head  <= tail;
    end else begin
      if (strobes.finWe[0]) begin
        done[finTag0] <= 1'b1;
        excF[finTag0] <= finExc[0];
      end
      if (strobes.finWe[1]) begin
        done[finTag1] <= 1'b1;
        excF[finTag1] <= finExc[1];
      end
      if (ret0) begin
        busy[head] <= 1'b0;
        done[head] <= 1'b0;
      end
      if (ret1) begin
        busy[nextSlot] <= 1'b0;
        done[nextSlot] <= 1'b0;
      end
      if (strobes.dispWe[0]) begin
        busy[tail] <= 1'b1;
        done[tail] <= 1'b0;
        excF[tail] <= 1'b0;
      end
      if (strobes.dispWe[1]) begin
        busy[tailNext] <= 1'b1;
        done[tailNext] <= 1'b0;
        excF[tailNext] <= 1'b0;
      end
      head  <= ret1 ? wrapInc(nextSlot) : (ret0 ? nextSlot : head);
      tail  <= strobes.dispWe[1] ? wrapInc(tailNext) : (strobes.dispWe[0] ? tailNext : tail);
      count <= count - CNT_W'(ret0) - CNT_W'(ret1)
                     + CNT_W'(strobes.dispWe[0]) + CNT_W'(strobes.dispWe[1]);
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R2
  disp_free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dispWe[0] |-> !busy[tail]);
  // R5
  retire_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    retireValid[0] |-> busy[head]);
  // R4
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done & ~busy) == '0);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (busy == '0 && count == '0));
endmodule

// File: rtl/drqData.sv
module drqData
  import drqPkg::*;
#(
  parameter int DEPTH    = 5,
  parameter int NUM_ARCH = 8,
  parameter int DATA_W   = 16,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int ARCH_W = $clog2(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  drqStrobes_t       strobes,
  input  logic [TAG_W-1:0]  dispTag0,
  input  logic [TAG_W-1:0]  dispTag1,
  input  logic [ARCH_W-1:0] dispDest0,
  input  logic [ARCH_W-1:0] dispDest1,
  input  logic [TAG_W-1:0]  finTag0,
  input  logic [TAG_W-1:0]  finTag1,
  input  logic [DATA_W-1:0] finData0,
  input  logic [DATA_W-1:0] finData1,
  input  logic [TAG_W-1:0]  headSlot,
  input  logic [TAG_W-1:0]  nextSlot,
  input  logic [ARCH_W-1:0] archRdAddr,
  output logic [DATA_W-1:0] archRdData
);
  logic [DATA_W-1:0] renameFile [DEPTH];
  logic [ARCH_W-1:0] destOf     [DEPTH];
  logic [DATA_W-1:0] archFile   [NUM_ARCH];

  always_ff @(posedge clk) begin
    if (strobes.dispWe[0]) destOf[dispTag0] <= dispDest0;
    if (strobes.dispWe[1]) destOf[dispTag1] <= dispDest1;
    if (strobes.finWe[0])  renameFile[finTag0] <= finData0;
    if (strobes.finWe[1])  renameFile[finTag1] <= finData1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ARCH; i++) archFile[i] <= '0;
    end else begin
      if (strobes.retWe[0]) archFile[destOf[headSlot]] <= renameFile[headSlot];
      if (strobes.retWe[1]) archFile[destOf[nextSlot]] <= renameFile[nextSlot];
    end
  end

  assign archRdData = archFile[archRdAddr];

  // R10
  fin_not_retiring_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finWe[0] && strobes.retWe[0]) |-> (finTag0 != headSlot));
endmodule

// File: rtl/dualRetireQueue.sv
module dualRetireQueue
  import drqPkg::*;
#(
  parameter int DEPTH    = 5,
  parameter int NUM_ARCH = 8,
  parameter int DATA_W   = 16,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int ARCH_W = $clog2(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        dispValid,
  input  logic [ARCH_W-1:0] dispDest0,
  input  logic [ARCH_W-1:0] dispDest1,
  output logic              dispReady,
  output logic [TAG_W-1:0]  dispTag0,
  output logic [TAG_W-1:0]  dispTag1,
  input  logic [1:0]        finValid,
  input  logic [TAG_W-1:0]  finTag0,
  input  logic [TAG_W-1:0]  finTag1,
  input  logic [DATA_W-1:0] finData0,
  input  logic [DATA_W-1:0] finData1,
  input  logic [1:0]        finExc,
  output logic [1:0]        retireValid,
  output logic              excReq,
  output logic [TAG_W-1:0]  excTag,
  input  logic [ARCH_W-1:0] archRdAddr,
  output logic [DATA_W-1:0] archRdData
);
  drqStrobes_t      strobes;
  logic [TAG_W-1:0] headSlot, nextSlot;

  drqCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
    .dispTag0(dispTag0), .dispTag1(dispTag1), .finValid(finValid),
    .finTag0(finTag0), .finTag1(finTag1), .finExc(finExc),
    .retireValid(retireValid), .excReq(excReq), .excTag(excTag),
    .headSlot(headSlot), .nextSlot(nextSlot), .strobes(strobes)
  );

  drqData #(.DEPTH(DEPTH), .NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dispTag0(dispTag0), .dispTag1(dispTag1),
    .dispDest0(dispDest0), .dispDest1(dispDest1),
    .finTag0(finTag0), .finTag1(finTag1),
    .finData0(finData0), .finData1(finData1),
    .headSlot(headSlot), .nextSlot(nextSlot),
    .archRdAddr(archRdAddr), .archRdData(archRdData)
  );
endmodule

// File: tb/dualRetireQueue_test.sv
module dualRetireQueue_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  dispValid = '0;
  logic [2:0]  dispDest0 = '0, dispDest1 = '0;
  logic        dispReady;
  logic [2:0]  dispTag0, dispTag1;
  logic [1:0]  finValid = '0;
  logic [2:0]  finTag0 = '0, finTag1 = '0;
  logic [15:0] finData0 = '0, finData1 = '0;
  logic [1:0]  finExc = '0;
  logic [1:0]  retireValid;
  logic        excReq;
  logic [2:0]  excTag;
  logic [2:0]  archRdAddr = '0;
  logic [15:0] archRdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dualRetireQueue uut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispDest0(dispDest0),
    .dispDest1(dispDest1), .dispReady(dispReady), .dispTag0(dispTag0),
    .dispTag1(dispTag1), .finValid(finValid), .finTag0(finTag0),
    .finTag1(finTag1), .finData0(finData0), .finData1(finData1),
    .finExc(finExc), .retireValid(retireValid), .excReq(excReq),
    .excTag(excTag), .archRdAddr(archRdAddr), .archRdData(archRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    dispValid = '0;
    finValid  = '0;
    finExc    = '0;
    #1;
  endtask

  task automatic disp(input logic [1:0] v, input logic [2:0] d0, input logic [2:0] d1);
    dispValid = v; dispDest0 = d0; dispDest1 = d1;
  endtask

  task automatic fin(input int port, input logic [2:0] tag, input logic [15:0] val,
                     input logic exc);
    if (port == 0) begin
      finValid[0] = 1'b1; finTag0 = tag; finData0 = val; finExc[0] = exc;
    end else begin
      finValid[1] = 1'b1; finTag1 = tag; finData1 = val; finExc[1] = exc;
    end
  endtask

  task automatic arch(input string req, input logic [2:0] a, input logic [15:0] exp);
    archRdAddr = a;
    #1;
    chk(req, {16'h0, archRdData}, {16'h0, exp});
  endtask

  task automatic testReset();
    chk("R1 ready", dispReady, 1);
    chk("R1 retire", retireValid, 0);
    chk("R1 exc", excReq, 0);
    chk("R1 tag0", dispTag0, 0);
    chk("R1 tag1", dispTag1, 1);
    arch("R1 arch", 3, 16'h0);
  endtask

  task automatic testInOrder();
    disp(2'b11, 1, 2);
    tick();
    chk("R2 tags advance", dispTag0, 2);
    fin(0, 1, 16'hBBBB, 0);
    tick();
    chk("R5 younger held", retireValid, 2'b00);
    arch("R4 rename only", 2, 16'h0);
    fin(1, 0, 16'hAAAA, 0);
    tick();
    chk("R6 pair retires", retireValid, 2'b11);
    arch("R7 before edge", 1, 16'h0);
    tick();
    arch("R7 dest1", 1, 16'hAAAA);
    arch("R7 dest2", 2, 16'hBBBB);
    chk("R6 idle", retireValid, 2'b00);
  endtask

  task automatic testFullAndSameDest();
    disp(2'b11, 3, 4);
    tick();
    disp(2'b11, 5, 5);
    tick();
    chk("R2 wrap tag1", dispTag1, 2);
    chk("R3 full not ready", dispReady, 0);
    disp(2'b11, 6, 6);
    tick();
    chk("R3 ignored tag", dispTag0, 1);
    fin(0, 2, 16'h0022, 0);
    fin(1, 3, 16'h0033, 0);
    tick();
    chk("R6 second pair", retireValid, 2'b11);
    tick();
    arch("R7 dest3", 3, 16'h0022);
    arch("R7 dest4", 4, 16'h0033);
    chk("R3 ready again", dispReady, 1);
    fin(0, 4, 16'h0044, 0);
    fin(1, 0, 16'h0055, 0);
    tick();
    tick();
    arch("R7 younger wins", 5, 16'h0055);
    arch("R3 ignored dest", 6, 16'h0);
  endtask

  task automatic testIgnoredFinish();
    fin(0, 1, 16'h0099, 0);
    tick();
    disp(2'b01, 6, 0);
    tick();
    chk("R10 stale finish", retireValid, 2'b00);
    fin(0, 1, 16'h0066, 0);
    tick();
    chk("R6 single", retireValid, 2'b01);
    tick();
    arch("R7 dest6", 6, 16'h0066);
    disp(2'b01, 7, 0);
    tick();
    fin(1, 2, 16'h0077, 0);
    tick();
    fin(1, 2, 16'h0078, 0);
    tick();
    arch("R10 refinish", 7, 16'h0077);
  endtask

  task automatic testHeadException();
    disp(2'b11, 1, 2);
    tick();
    fin(0, 3, 16'h00EE, 1);
    fin(1, 4, 16'h00FF, 0);
    tick();
    chk("R8 excReq", excReq, 1);
    chk("R8 excTag", excTag, 3);
    chk("R8 no retire", retireValid, 2'b00);
    chk("R3 ready low at exc", dispReady, 0);
    tick();
    chk("R8 exc clears", excReq, 0);
    chk("R8 empty", dispReady, 1);
    chk("R8 tail kept", dispTag0, 0);
    arch("R8 head kept", 1, 16'hAAAA);
    arch("R8 younger flushed", 2, 16'hBBBB);
  endtask

  task automatic testSecondException();
    disp(2'b11, 3, 4);
    tick();
    fin(0, 0, 16'h0030, 0);
    fin(1, 1, 16'h0031, 1);
    tick();
    chk("R9 first alone", retireValid, 2'b01);
    chk("R9 no exc yet", excReq, 0);
    tick();
    chk("R9 exc next", excReq, 1);
    chk("R9 exc tag", excTag, 1);
    tick();
    arch("R9 first committed", 3, 16'h0030);
    arch("R9 faulting kept", 4, 16'h0033);
  endtask

  task automatic testLaneOne();
    disp(2'b10, 5, 5);
    tick();
    chk("R11 lane1 alone", dispTag0, 2);
    chk("R11 retire", retireValid, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testInOrder();
    testFullAndSameDest();
    testIgnoredFinish();
    testHeadException();
    testSecondException();
    testLaneOne();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule